// File: doc/BRIEF.md
# Multi-CPU interrupt enable and acknowledge controller

This block collects level-sensitive interrupt sources and presents one interrupt line to each of up to four CPUs. A source reaches a CPU only when three conditions hold together: the source is switched on globally, the CPU has not masked it, and the source's routing word includes that CPU. A CPU that sees its line high reads its own acknowledge register. That read returns the lowest-numbered source currently qualifying for that CPU, or a reserved idle number when nothing qualifies. Reading does not clear anything, because the sources are levels. The CPU clears the condition at the device that raised it.

Software never performs read-modify-write on bitmaps. It writes a source number to a set or clear register, and only that one source changes. Global enables are common to all CPUs. Each CPU has its own set-mask and clear-mask registers. The CPU that performs a per-CPU access is given on the `bus_cpu` input alongside the access.

Three source numbers are private to each CPU: 0 (doorbell summary), 1 (message-signalled summary) and 5 (local timer). These are fed from per-CPU lines rather than from the shared source vector, and only that CPU's mask gates them.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset every source is globally disabled, masked on every CPU and routed to no CPU. All `cpu_irq` bits are 0, every acknowledge read returns 1023, and every routing word reads 0, whatever the source inputs are. Enabling and routing a source without unmasking it leaves it invisible.
- R2: Writing source number n in `bus_wdata[9:0]` to address 0x010 enables n, and writing it to 0x014 disables n. The enable of every other source keeps its value.
- R3: Writing n to 0x024 masks n for the CPU named by `bus_cpu`, and writing n to 0x028 unmasks it. The masks of the other CPUs are not affected.
- R4: The routing word of source n is at address 0x100 + 4n. Bit c of its low NUM_CPU bits allows CPU c to receive the source. Higher data bits are dropped, and reading the address returns the stored bits zero-extended.
- R5: A read of address 0x000 returns NUM_SRC in bits [11:2] and zero elsewhere.
- R6: A shared source that is high, enabled, unmasked for CPU c and routed to c raises `cpu_irq[c]` at the first rising clock edge after the condition holds.
- R7: A read of address 0x020 returns, one cycle later in `bus_rdata[9:0]`, the lowest source number qualifying for the CPU named by `bus_cpu`. It returns 1023 when no source qualifies. A read has no side effect.
- R8: Sources 0, 1 and 5 for CPU c come from `pcpu_level[c*3+0]`, `pcpu_level[c*3+1]` and `pcpu_level[c*3+2]` respectively. Only CPU c's mask gates them. The global enable, the routing word and `src_level` bits 0, 1 and 5 have no effect on them.
- R9: An enable, mask or routing write whose source number is NUM_SRC or above changes no state. A read of such a routing address returns 0.
- R10: When a qualifying source falls, `cpu_irq` drops at the next rising edge and the acknowledge register returns the next-lowest source or 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Shared level-sensitive sources; bits 0, 1, 5 unused |
| pcpu_level | input | NUM_CPU*3 | Private per-CPU levels: doorbell, message, timer per CPU |
| bus_cpu | input | CPU_W | CPU performing the current access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid the next cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data (source number or routing bits) |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Registered interrupt line per CPU |

## Verification
The bench targets lowest-number selection when several sources qualify at once, including cases where a private source undercuts a shared one. A design with reversed priority or a broken encoder would return the wrong number. It also drives the private numbers on the shared vector and clears their global enables, so a design that gated private sources like shared ones would raise or drop lines it should not. Index writes at and above the source count, including a value whose low bits alias a live source, would alter a live source in a design that truncated the index. Routing writes with stray high data bits would read back wider than the CPU count in a design that failed to drop those bits.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 10;
    localparam int NUM_LOCAL = 3;

    // Returned by the acknowledge register when nothing is pending.
    localparam logic [ID_W-1:0] NO_IRQ_ID = '1;

    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 12'h010;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 12'h014;
    localparam logic [ADDR_W-1:0] A_ACK     = 12'h020;
    localparam logic [ADDR_W-1:0] A_MSK_SET = 12'h024;
    localparam logic [ADDR_W-1:0] A_MSK_CLR = 12'h028;
    localparam logic [ADDR_W-1:0] A_ROUTE   = 12'h100;

    typedef enum logic [2:0] {
        K_NONE,
        K_CTRL,
        K_EN_SET,
        K_EN_CLR,
        K_ACK,
        K_MSK_SET,
        K_MSK_CLR,
        K_ROUTE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [ID_W-1:0] slot;
    } reg_sel_t;

    // Position of a private per-CPU source in its CPU's local group, -1 if shared.
    function automatic int local_slot(input int src);
        case (src)
            0:       return 0;
            1:       return 1;
            5:       return 2;
            default: return -1;
        endcase
    endfunction

    // Address decode; slot carries the source number for routing words.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t r;
        r.kind = K_NONE;
        r.slot = '0;
        if (a >= A_ROUTE) begin
            if (a[1:0] == 2'b00) begin
                r.kind = K_ROUTE;
                r.slot = a[ADDR_W-1:2] - A_ROUTE[ADDR_W-1:2];
            end
        end else begin
            case (a)
                A_CTRL:    r.kind = K_CTRL;
                A_EN_SET:  r.kind = K_EN_SET;
                A_EN_CLR:  r.kind = K_EN_CLR;
                A_ACK:     r.kind = K_ACK;
                A_MSK_SET: r.kind = K_MSK_SET;
                A_MSK_CLR: r.kind = K_MSK_CLR;
                default:   r.kind = K_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mpirq_regs.sv
module mpirq_regs
    import mpirq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  reg_sel_t                          wr_sel,
    input  logic [NUM_CPU-1:0]                wr_cpu_hot,
    input  logic [NUM_CPU-1:0]                wr_route,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);

    // One-hot of the addressed source; all zero when the number is out of range.
    logic [NUM_SRC-1:0] sel_vec;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
        assign sel_vec[s] = (wr_sel.slot == ID_W'(s));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            msk_q   <= '1;
            route_q <= '0;
        end else if (wr_en) begin
            case (wr_sel.kind)
                K_EN_SET: en_q <= en_q | sel_vec;
                K_EN_CLR: en_q <= en_q & ~sel_vec;
                K_MSK_SET: begin
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (wr_cpu_hot[c]) msk_q[c] <= msk_q[c] | sel_vec;
                    end
                end
                K_MSK_CLR: begin
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (wr_cpu_hot[c]) msk_q[c] <= msk_q[c] & ~sel_vec;
                    end
                end
                K_ROUTE: begin
                    for (int s = 0; s < NUM_SRC; s++) begin
                        if (sel_vec[s]) route_q[s] <= wr_route;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel.kind == K_EN_SET) |=> ((en_q & $past(sel_vec)) == $past(sel_vec)));

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel.kind == K_EN_CLR) |=> ((en_q & $past(sel_vec)) == '0));

    assert_en_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel.kind == K_EN_SET || wr_sel.kind == K_EN_CLR))
        |=> (((en_q ^ $past(en_q)) & ~$past(sel_vec)) == '0));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_mchk
        assert_mask_other_cpu_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel.kind == K_MSK_SET || wr_sel.kind == K_MSK_CLR) && !wr_cpu_hot[c])
            |=> $stable(msk_q[c]));
    end

    assert_range_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_vec == '0) |=> ($stable(en_q) && $stable(msk_q) && $stable(route_q)));

endmodule

// File: rtl/mpirq_sel.sv
module mpirq_sel
    import mpirq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_level,
    input  logic [NUM_LOCAL-1:0] loc_level,
    input  logic [NUM_SRC-1:0]   en,
    input  logic [NUM_SRC-1:0]   msk,
    input  logic [NUM_SRC-1:0]   rt,
    output logic                 irq_q,
    output logic [ID_W-1:0]      ack_id
);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] unused_bits;
    logic [ID_W-1:0]    id_or;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int LS = local_slot(s);
        if (LS >= 0) begin : g_local
            assign elig[s]        = loc_level[LS] & ~msk[s];
            assign unused_bits[s] = src_level[s] ^ en[s] ^ rt[s];

            assert_local_bypass_R8: assert property (@(posedge clk) disable iff (rst)
                (loc_level[LS] && !msk[s]) |-> (ack_id <= ID_W'(s)));
        end else begin : g_shared
            assign elig[s]        = src_level[s] & en[s] & ~msk[s] & rt[s];
            assign unused_bits[s] = 1'b0;
        end
    end

    // Lowest set bit wins.
    assign grant = elig & (-elig);

    always_comb begin
        id_or = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (grant[s]) id_or = id_or | ID_W'(s);
        end
    end

    assign ack_id = (|elig) ? id_or : NO_IRQ_ID;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |elig;
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_irq_tracks_ack_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == $past(ack_id != NO_IRQ_ID)));

endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
    import mpirq_pkg::*;
#(
    parameter  int NUM_SRC = 32,
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            src_level,
    input  logic [NUM_CPU*NUM_LOCAL-1:0]  pcpu_level,
    input  logic [CPU_W-1:0]              bus_cpu,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NUM_CPU-1:0]            cpu_irq
);

    localparam logic [ID_W-1:0] SRC_LIMIT = ID_W'(NUM_SRC);

    reg_sel_t                          sel;
    reg_sel_t                          wr_sel;
    logic [NUM_CPU-1:0]                cpu_hot;
    logic [NUM_SRC-1:0]                en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]   rt_col;
    logic [NUM_CPU-1:0][ID_W-1:0]      ack_id;
    logic [ID_W-1:0]                   ack_sel;
    logic [NUM_CPU-1:0]                route_rd;
    logic                              wdata_unused;

    assign sel          = decode_addr(bus_addr);
    assign wdata_unused = ^bus_wdata[DATA_W-1:ID_W];

    // Index registers take the source number from data, routing words from address.
    always_comb begin
        wr_sel.kind = sel.kind;
        wr_sel.slot = (sel.kind == K_ROUTE) ? sel.slot : bus_wdata[ID_W-1:0];
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_hot
        assign cpu_hot[c] = (bus_cpu == CPU_W'(c));
    end

    mpirq_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .wr_sel     (wr_sel),
        .wr_cpu_hot (cpu_hot),
        .wr_route   (bus_wdata[NUM_CPU-1:0]),
        .en_q       (en_q),
        .msk_q      (msk_q),
        .route_q    (route_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
            assign rt_col[c][s] = route_q[s][c];
        end

        mpirq_sel #(
            .NUM_SRC (NUM_SRC)
        ) u_sel (
            .clk       (clk),
            .rst       (rst),
            .src_level (src_level),
            .loc_level (pcpu_level[c*NUM_LOCAL +: NUM_LOCAL]),
            .en        (en_q),
            .msk       (msk_q[c]),
            .rt        (rt_col[c]),
            .irq_q     (cpu_irq[c]),
            .ack_id    (ack_id[c])
        );
    end

    always_comb begin
        ack_sel = NO_IRQ_ID;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu_hot[c]) ack_sel = ack_id[c];
        end
    end

    always_comb begin
        route_rd = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (sel.slot == ID_W'(s)) route_rd = route_q[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel.kind)
                K_CTRL:  bus_rdata <= {{(DATA_W-ID_W-2){1'b0}}, SRC_LIMIT, 2'b00};
                K_ACK:   bus_rdata <= DATA_W'(ack_sel);
                K_ROUTE: bus_rdata <= DATA_W'(route_rd);
                default: bus_rdata <= '0;
            endcase
        end
    end

    assert_ctrl_count_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel.kind == K_CTRL) |=> (bus_rdata[11:2] == SRC_LIMIT));

    assert_idle_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel.kind == K_ACK && ack_sel == NO_IRQ_ID) |=> (bus_rdata[ID_W-1:0] == NO_IRQ_ID));

endmodule

// File: tb/tb_mpirq_ctrl.sv
module tb_mpirq_ctrl;
    import mpirq_pkg::*;

    localparam int NS   = 32;
    localparam int NC   = 4;
    localparam int NL   = NUM_LOCAL;
    localparam int NONE = 1023;

    localparam logic [11:0] R_CTRL    = 12'h000;
    localparam logic [11:0] R_EN_SET  = 12'h010;
    localparam logic [11:0] R_EN_CLR  = 12'h014;
    localparam logic [11:0] R_ACK     = 12'h020;
    localparam logic [11:0] R_MSK_SET = 12'h024;
    localparam logic [11:0] R_MSK_CLR = 12'h028;

    localparam int NV = 14;
    localparam logic [31:0] V_SRC [NV] = '{
        32'h0000_0000, 32'h0000_0008, 32'h0000_0080, 32'h0000_0088,
        32'h0010_0000, 32'h8010_0200, 32'h0000_0004, 32'h0000_0023,
        32'h0000_0008, 32'h0000_0080, 32'h0000_0000, 32'h0000_0000,
        32'h0000_0000, 32'hFFFF_FFFF};
    localparam logic [11:0] V_PCPU [NV] = '{
        12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000,
        12'h000, 12'h001, 12'h020, 12'h0C0, 12'hE00, 12'h00C, 12'hFFF};
    localparam int V_ACK [NV][NC] = '{
        '{NONE, NONE, NONE, NONE},
        '{3,    NONE, NONE, NONE},
        '{7,    7,    NONE, NONE},
        '{3,    7,    NONE, NONE},
        '{20,   20,   20,   NONE},
        '{20,   20,   9,    31},
        '{NONE, NONE, NONE, NONE},
        '{NONE, NONE, NONE, NONE},
        '{0,    NONE, NONE, NONE},
        '{7,    5,    NONE, NONE},
        '{NONE, NONE, 1,    NONE},
        '{NONE, NONE, NONE, NONE},
        '{NONE, NONE, NONE, NONE},
        '{0,    5,    1,    31}};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS-1:0]     src_level = '1;
    logic [NC*NL-1:0]  pcpu_level = '1;
    logic [1:0]        bus_cpu = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     cpu_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mpirq_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC)) dut (
        .clk        (clk),
        .rst        (rst),
        .src_level  (src_level),
        .pcpu_level (pcpu_level),
        .bus_cpu    (bus_cpu),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cpu_irq    (cpu_irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = 2'(cpu); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_ack(input string req, input int cpu, input int exp);
        logic [31:0] d;
        bus_read(cpu, R_ACK, d);
        check(req, $sformatf("ack cpu%0d", cpu), d, 32'(exp));
    endtask

    task automatic set_inputs(input logic [NS-1:0] s, input logic [NC*NL-1:0] p);
        @(negedge clk);
        src_level = s; pcpu_level = p;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NC-1:0] exp_irq;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state with every input driven high
        check("R1", "cpu_irq after reset", 32'(cpu_irq), 32'h0);
        for (int c = 0; c < NC; c++) check_ack("R1", c, NONE);
        bus_read(0, 12'h10C, d);
        check("R1", "route word src3 after reset", d, 32'h0);
        // R5: source count in bits [11:2]
        bus_read(2, R_CTRL, d);
        check("R5", "control register", d, 32'(NS) << 2);

        // R1: enabled and routed but still masked by reset
        bus_write(0, R_EN_SET, 32'd3);
        bus_write(0, 12'h10C, 32'h1);
        check_ack("R1", 0, NONE);

        // configuration for the vector table
        bus_write(0, R_EN_SET, 32'd7);
        bus_write(0, R_EN_SET, 32'd9);
        bus_write(0, R_EN_SET, 32'd20);
        bus_write(0, R_EN_SET, 32'd31);
        bus_write(0, 12'h108, 32'hF);
        bus_write(0, 12'h11C, 32'h3);
        bus_write(0, 12'h124, 32'h4);
        bus_write(0, 12'h150, 32'hF);
        bus_write(0, 12'h17C, 32'h8);
        bus_write(0, R_MSK_CLR, 32'd2);
        bus_write(0, R_MSK_CLR, 32'd3);
        bus_write(0, R_MSK_CLR, 32'd7);
        bus_write(0, R_MSK_CLR, 32'd20);
        bus_write(0, R_MSK_CLR, 32'd0);
        bus_write(1, R_MSK_CLR, 32'd7);
        bus_write(1, R_MSK_CLR, 32'd20);
        bus_write(1, R_MSK_CLR, 32'd5);
        bus_write(2, R_MSK_CLR, 32'd9);
        bus_write(2, R_MSK_CLR, 32'd20);
        bus_write(2, R_MSK_CLR, 32'd1);
        bus_write(3, R_MSK_CLR, 32'd31);

        // vector table: R6 line, R7 lowest number, R8 private sources
        for (int v = 0; v < NV; v++) begin
            set_inputs(V_SRC[v], V_PCPU[v]);
            for (int c = 0; c < NC; c++) exp_irq[c] = (V_ACK[v][c] != NONE);
            check("R6", $sformatf("cpu_irq vector %0d", v), 32'(cpu_irq), 32'(exp_irq));
            for (int c = 0; c < NC; c++)
                check_ack((v >= 7) ? "R8" : "R7", c, V_ACK[v][c]);
        end

        // R2: clear and re-set the enable of one source only
        set_inputs(32'h0000_0088, '0);
        bus_write(0, R_EN_CLR, 32'd7);
        check_ack("R2", 0, 3);
        check_ack("R2", 1, NONE);
        bus_write(0, R_EN_SET, 32'd7);
        check_ack("R2", 1, 7);

        // R3: mask on CPU1 leaves CPU0 alone
        set_inputs(32'h0000_0080, '0);
        bus_write(1, R_MSK_SET, 32'd7);
        check_ack("R3", 1, NONE);
        check_ack("R3", 0, 7);
        bus_write(1, R_MSK_CLR, 32'd7);
        check_ack("R3", 1, 7);

        // R9: out-of-range numbers change nothing
        set_inputs(32'h0000_0008, '0);
        bus_write(0, R_EN_CLR, 32'd35);
        bus_write(0, R_MSK_SET, 32'd35);
        check_ack("R9", 0, 3);
        bus_write(0, 12'h180, 32'hF);
        bus_read(0, 12'h180, d);
        check("R9", "route word beyond range", d, 32'h0);
        bus_read(0, 12'h10C, d);
        check("R9", "route word src3 kept", d, 32'h1);

        // R8: timer ignores global enable and routing
        set_inputs('0, 12'h020);
        bus_write(0, R_EN_CLR, 32'd5);
        bus_write(0, 12'h114, 32'h0);
        check_ack("R8", 1, 5);
        check("R8", "cpu_irq timer", 32'(cpu_irq), 32'h2);
        bus_write(1, R_MSK_SET, 32'd5);
        check_ack("R8", 1, NONE);

        // R10: level follows source, reads do not clear
        set_inputs(32'h0000_0008, '0);
        check("R10", "cpu_irq source high", 32'(cpu_irq), 32'h1);
        check_ack("R10", 0, 3);
        check_ack("R10", 0, 3);
        set_inputs('0, '0);
        check("R10", "cpu_irq source low", 32'(cpu_irq), 32'h0);
        check_ack("R10", 0, NONE);

        // R4: routing word keeps only CPU bits
        bus_write(0, 12'h11C, 32'hFFFF_FFF2);
        bus_read(0, 12'h11C, d);
        check("R4", "route word src7 readback", d, 32'h2);
        set_inputs(32'h0000_0080, '0);
        check_ack("R4", 1, 7);
        check_ack("R4", 0, NONE);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule